// File: doc/BRIEF.md
# Carrier-Cycle Symbol Interval Classifier

This block sits behind a level slicer in a low-frequency tag reader. The carrier runs at 125 kHz, so one carrier period is 8 µs. The slicer's output is sampled once per pulse of a 62.5 kHz strobe, which is one sample every 16 µs. The block counts how many strobes the sliced level stays unchanged. When the level changes, it reports the run that just ended as one of four nominal lengths:

| Carrier cycles | Duration | Strobes |
|---|---|---|
| 16 | 128 µs | 8 |
| 32 | 256 µs | 16 |
| 48 | 384 µs | 24 |
| 64 | 512 µs | 32 |

The upstream filtering distorts run lengths. The shortest runs stretch by up to about 37%, and the longest shrink by about 9%. For that reason each class covers the whole span between midpoints, rather than a narrow band around its nominal length. A run outside the plausible span is flagged as an error. Turning the class stream into data bits is left to a later stage.

Top module: `symrun_classifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sym_valid`, `sym_err` and `sym_pol` are 0 and `sym_class` is 00.
- R2: `lvl_in` is sampled only in cycles where `smp_stb` is 1. Changes of `lvl_in` in other cycles have no effect on any output.
- R3: The length of a run is the number of strobes that sampled the same level. The first strobe after reset only records the level. The run that ends at the first level change after reset is discarded and produces no `sym_valid`.
- R4: When a strobe samples a level that differs from the previous strobe's level, `sym_valid` is 1 for exactly the following clock cycle. In that cycle `sym_pol` gives the level that the finished run held.
- R5: A run of 4 to 11 strobes gives class code 00 (16 cycles). A run of 12 to 19 strobes gives 01 (32 cycles). A run of 20 to 27 strobes gives 10 (48 cycles). A run of 28 to 40 strobes gives 11 (64 cycles). In all these cases `sym_err` is 0.
- R6: A finished run shorter than 4 strobes or longer than 40 strobes sets `sym_err` to 1 together with `sym_valid`, with `sym_class` at 00.
- R7: The run counter holds at its maximum of 63 instead of wrapping. For example, a 100-strobe run is reported as an error, not as a wrapped 36-strobe run.
- R8: `sym_err` is never 1 without `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe, one cycle wide |
| lvl_in | input | 1 | Sliced symbol level |
| sym_valid | output | 1 | One-cycle pulse: a run has been classified |
| sym_class | output | 2 | Class code: 00=16, 01=32, 10=48, 11=64 cycles |
| sym_pol | output | 1 | Level held during the reported run |
| sym_err | output | 1 | Run length was out of range |

## Verification
A stale reference level, or a counter that reloads at the wrong value, shifts every reported length by one strobe. This shows at the ports on the very next run that ends next to a class boundary. For that reason the stimulus places runs on both sides of every boundary: 3/4, 11/12, 19/20, 27/28 and 40/41. If the discard flag is not armed, an extra valid pulse appears right at the first edge after reset. If the counter wraps, a 100-strobe run comes out as a valid class 11 in the cycle after its ending strobe, instead of as an error.

// File: rtl/symrun_pkg.sv
package symrun_pkg;

    typedef enum logic [1:0] {
        CLS_C16 = 2'b00,
        CLS_C32 = 2'b01,
        CLS_C48 = 2'b10,
        CLS_C64 = 2'b11
    } sym_class_e;

    typedef struct packed {
        logic       valid;
        sym_class_e cls;
        logic       pol;
        logic       err;
    } sym_result_t;

    // Map a run length to a class, given the lower bounds of classes 1..3
    function automatic sym_class_e run_to_class(
        input int unsigned len,
        input int unsigned lo_c32,
        input int unsigned lo_c48,
        input int unsigned lo_c64
    );
        if (len >= lo_c64)      return CLS_C64;
        else if (len >= lo_c48) return CLS_C48;
        else if (len >= lo_c32) return CLS_C32;
        else                    return CLS_C16;
    endfunction

    function automatic logic run_in_range(
        input int unsigned len,
        input int unsigned lo,
        input int unsigned hi
    );
        return (len >= lo) && (len <= hi);
    endfunction

endpackage

// File: rtl/symrun_edge.sv
module symrun_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic lvl,
    output logic held_lvl,
    output logic primed,
    output logic edge_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_lvl <= 1'b0;
            primed   <= 1'b0;
        end else if (stb) begin
            held_lvl <= lvl;
            primed   <= 1'b1;
        end
    end

    assign edge_evt = stb && primed && (lvl != held_lvl);

    // R2
    ref_level_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(held_lvl));
endmodule

// File: rtl/symrun_count.sv
module symrun_count #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             edge_evt,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (stb) begin
            if (edge_evt) begin
                cnt   <= CNT_ONE;
                armed <= 1'b1;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !edge_evt) |=> (cnt >= $past(cnt)));

    // R3
    restart_one_chk: assert property (@(posedge clk) disable iff (rst)
        edge_evt |=> (cnt == CNT_ONE) && armed);
endmodule

// File: rtl/symrun_decide.sv
module symrun_decide
    import symrun_pkg::*;
#(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MIN_LEN = 4,
    parameter int unsigned LO_C32  = 12,
    parameter int unsigned LO_C48  = 20,
    parameter int unsigned LO_C64  = 28,
    parameter int unsigned MAX_LEN = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CNT_W-1:0] len,
    input  logic             pol,
    output sym_result_t      res
);
    sym_result_t nxt;
    logic        ok;

    always_comb begin
        ok        = run_in_range(int'(len), MIN_LEN, MAX_LEN);
        nxt       = '0;
        nxt.valid = take;
        if (take) begin
            nxt.pol = pol;
            nxt.err = !ok;
            nxt.cls = ok ? run_to_class(int'(len), LO_C32, LO_C48, LO_C64) : CLS_C16;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= nxt;
    end

    // R6
    good_len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.err) |-> ($past(len) >= CNT_W'(MIN_LEN)) && ($past(len) <= CNT_W'(MAX_LEN)));

    // R5
    long_class_len_chk: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.err && res.cls == CLS_C64) |-> ($past(len) >= CNT_W'(LO_C64)));

    // R8
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res.err |-> res.valid);
endmodule

// File: rtl/symrun_classifier.sv
module symrun_classifier
    import symrun_pkg::*;
#(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MIN_LEN = 4,
    parameter int unsigned LO_C32  = 12,
    parameter int unsigned LO_C48  = 20,
    parameter int unsigned LO_C64  = 28,
    parameter int unsigned MAX_LEN = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_stb,
    input  logic       lvl_in,
    output logic       sym_valid,
    output logic [1:0] sym_class,
    output logic       sym_pol,
    output logic       sym_err
);
    logic             held_lvl;
    logic             primed;
    logic             edge_evt;
    logic [CNT_W-1:0] run_cnt;
    logic             armed;
    sym_result_t      res;

    symrun_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .lvl      (lvl_in),
        .held_lvl (held_lvl),
        .primed   (primed),
        .edge_evt (edge_evt)
    );

    symrun_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .edge_evt (edge_evt),
        .cnt      (run_cnt),
        .armed    (armed)
    );

    symrun_decide #(
        .CNT_W   (CNT_W),
        .MIN_LEN (MIN_LEN),
        .LO_C32  (LO_C32),
        .LO_C48  (LO_C48),
        .LO_C64  (LO_C64),
        .MAX_LEN (MAX_LEN)
    ) u_decide (
        .clk  (clk),
        .rst  (rst),
        .take (edge_evt && armed),
        .len  (run_cnt),
        .pol  (held_lvl),
        .res  (res)
    );

    assign sym_valid = res.valid;
    assign sym_class = res.cls;
    assign sym_pol   = res.pol;
    assign sym_err   = res.err;

    // R4
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(smp_stb) && $past(primed));
endmodule

// File: tb/sim_symrun_classifier.sv
module sim_symrun_classifier;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] cls;
        logic       pol;
        logic       err;
        int         len;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_stb = 1'b0;
    logic       lvl_in = 1'b0;
    logic       sym_valid;
    logic [1:0] sym_class;
    logic       sym_pol;
    logic       sym_err;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    int   runs_sent = 0;
    logic prev_lv = 1'b0;
    int   prev_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    symrun_classifier u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .lvl_in    (lvl_in),
        .sym_valid (sym_valid),
        .sym_class (sym_class),
        .sym_pol   (sym_pol),
        .sym_err   (sym_err)
    );

    function automatic exp_t model(input logic lv, input int n);
        exp_t e;
        int   m;
        m     = (n > 63) ? 63 : n;          // R7 saturation
        e.len = n;
        e.pol = lv;
        e.err = (m < 4) || (m > 40);        // R6
        if (e.err)       e.cls = 2'b00;
        else if (m >= 28) e.cls = 2'b11;    // R5
        else if (m >= 20) e.cls = 2'b10;
        else if (m >= 12) e.cls = 2'b01;
        else              e.cls = 2'b00;
        return e;
    endfunction

    // Driver: one run of n strobes; between strobes lvl_in carries garbage (R2)
    task automatic send_run(input logic lv, input int n);
        if (runs_sent >= 2) expq.push_back(model(prev_lv, prev_n));  // R3 first run discarded
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_stb = 1'b1;
            lvl_in  = lv;
            @(negedge clk);
            smp_stb = 1'b0;
            lvl_in  = ~lv;
        end
        prev_lv = lv;
        prev_n  = n;
        runs_sent++;
    endtask

    // Monitor
    logic last_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (last_valid && sym_valid) begin
                checks++; errors++;
                $display("FAIL R4: valid high two cycles, got 1 expected 0");
            end
            if (sym_err && !sym_valid) begin
                checks++; errors++;
                $display("FAIL R8: err=1 with valid=0, expected err=0");
            end
            if (sym_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R3: unexpected valid, class=%b pol=%b err=%b expected none",
                             sym_class, sym_pol, sym_err);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (sym_class !== e.cls || sym_pol !== e.pol || sym_err !== e.err) begin
                        errors++;
                        $display("FAIL R5/R6/R4 len=%0d: got class=%b pol=%b err=%b expected class=%b pol=%b err=%b",
                                 e.len, sym_class, sym_pol, sym_err, e.cls, e.pol, e.err);
                    end
                end
            end
        end
        last_valid = sym_valid;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        checks++;
        if (sym_valid !== 1'b0 || sym_class !== 2'b00 || sym_pol !== 1'b0 || sym_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%b class=%b pol=%b err=%b expected all 0",
                     sym_valid, sym_class, sym_pol, sym_err);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (sym_valid !== 1'b0 || sym_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: after release valid=%b err=%b expected 0 0", sym_valid, sym_err);
        end
        send_run(1'b1, 5);    // discarded (R3)
        send_run(1'b0, 8);
        send_run(1'b1, 3);    // R6 short
        send_run(1'b0, 4);    // R6 lower edge ok
        send_run(1'b1, 11);   // stretched short symbol
        send_run(1'b0, 12);   // R5 boundary
        send_run(1'b1, 16);
        send_run(1'b0, 19);
        send_run(1'b1, 20);
        send_run(1'b0, 24);
        send_run(1'b1, 27);
        send_run(1'b0, 28);
        send_run(1'b1, 29);   // shrunk long symbol
        send_run(1'b0, 32);
        send_run(1'b1, 40);
        send_run(1'b0, 41);   // R6 long
        send_run(1'b1, 1);
        send_run(1'b0, 100);  // R7 saturation
        send_run(1'b1, 8);
        send_run(1'b0, 2);    // terminates last measured run
        repeat (6) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d results missing, expected 0", expq.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule